// File: doc/BRIEF.md
# Control-Bit Datapath ALU with Post-Shifter

This block is the arithmetic and logic stage of a microcoded datapath. It is fully combinational from its operands to its result. The left operand comes from a holding register and the right operand comes from a bus. There is no opcode. The function is built from separate control bits:

- a two-bit function select;
- an enable for each operand;
- an invert for the left operand;
- a forced carry into the low-order bit of the adder.

Because of this, A+B, B−A, A+1, −A and the constants 0, 1 and −1 all come out of one adder. A shifter after the function unit can move the result left by a byte or right by one bit arithmetically.

Two status flip-flops, negative and zero, capture the unshifted function-unit result on every rising clock edge. This is the same edge at which the surrounding datapath loads its destination registers. The flags therefore describe the operation of the previous cycle. The register file, the bus multiplexers and the control store sit outside this block.

Top module: `mdp_alu`

## Requirements
- R1: When `en_left` is 0 the left operand reads as all zeros, and when `en_right` is 0 the right operand reads as all zeros. Each enable acts independently of the other.
- R2: When `inv_left` is 1 the left operand is bit-inverted after gating. A disabled and inverted left operand therefore reads as all ones.
- R3: `fn_sel` = 2'b00 gives the bitwise AND of the gated operands, and `fn_sel` = 2'b01 gives their bitwise OR.
- R4: `fn_sel` = 2'b10 gives the bitwise complement of the gated right operand. The left operand does not affect the result.
- R5: `fn_sel` = 2'b11 gives the sum of the gated left operand, the gated right operand and `carry_in`, modulo 2^32. B−A comes from `inv_left`=1 with `carry_in`=1, and −A comes from the same settings with `en_right`=0.
- R6: With `shl_byte`=1 and `shr_arith`=0, `c_out` is the function result shifted left by 8 bits, with zeros filled in at bits 7:0.
- R7: With `shr_arith`=1 and `shl_byte`=0, `c_out` is the function result shifted right by 1 bit, with bit 31 copied into the vacated top bit.
- R8: With both shift bits at 1, or both at 0, `c_out` equals the unshifted function result.
- R9: On each rising clock edge out of reset, `flag_n` loads bit 31 of the unshifted function result.
- R10: On each rising clock edge out of reset, `flag_z` loads 1 exactly when the unshifted function result is zero. A shift never changes the flag.
- R11: While `rst_n` is 0, both flags are held at 0 whatever the operands are.
- R12: `carry_in` has no effect on the result when `fn_sel` selects one of the three logic functions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock; the flags load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| a_hold | input | 32 | Left operand from the holding register |
| b_bus | input | 32 | Right operand from the bus |
| fn_sel | input | 2 | Function select: 00 AND, 01 OR, 10 NOT right, 11 sum |
| en_left | input | 1 | Enable for the left operand |
| en_right | input | 1 | Enable for the right operand |
| inv_left | input | 1 | Invert the gated left operand |
| carry_in | input | 1 | Forced carry into bit 0 of the sum |
| shl_byte | input | 1 | Shift the result left by 8 bits |
| shr_arith | input | 1 | Shift the result right by 1 bit, arithmetically |
| c_out | output | 32 | Shifted result |
| flag_n | output | 1 | Registered sign of the unshifted result |
| flag_z | output | 1 | Registered zero indication of the unshifted result |

## Verification
The bound checker watches several behaviours on every clock edge:

- the loading of both flags from the unshifted result of the previous cycle;
- the three shifter modes, including the conflicting combination;
- the AND and OR functions whenever both operands are enabled and not inverted.

Some behaviours can only be shown by the bench's directed vectors. These are the meaning of the enable, invert and carry combinations: the two's-complement identities for B−A and −A, and the constants 0, 1 and −1. The vectors also cover carry overflow at the word boundary, the immunity of the logic functions to `carry_in`, and the reset hold.

// File: rtl/mdp_alu_pkg.sv
package mdp_alu_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_SUM  = 2'b11
    } alu_fn_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'b00,
        SH_RIGHT = 2'b01,
        SH_LEFT  = 2'b10,
        SH_BOTH  = 2'b11
    } shift_e;

endpackage

// File: rtl/mdp_operand_gate.sv
module mdp_operand_gate #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             en_left,
    input  logic             en_right,
    input  logic             inv_left,
    output logic [WIDTH-1:0] a_eff,
    output logic [WIDTH-1:0] b_eff
);
    logic [WIDTH-1:0] a_gated;

    always_comb begin
        a_gated = en_left ? a_in : '0;
        a_eff   = inv_left ? ~a_gated : a_gated;
        b_eff   = en_right ? b_in : '0;
    end
endmodule

// File: rtl/mdp_func_unit.sv
module mdp_func_unit
    import mdp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_eff,
    input  logic [WIDTH-1:0] b_eff,
    input  logic [1:0]       fn_sel,
    input  logic             carry_in,
    output logic [WIDTH-1:0] res
);
    localparam int PADW = WIDTH - 1;

    alu_fn_e fn;

    always_comb begin
        fn = alu_fn_e'(fn_sel);
        unique case (fn)
            FN_AND:  res = a_eff & b_eff;
            FN_OR:   res = a_eff | b_eff;
            FN_NOTB: res = ~b_eff;
            FN_SUM:  res = a_eff + b_eff + {{PADW{1'b0}}, carry_in};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/mdp_shifter.sv
module mdp_shifter
    import mdp_alu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHL_AMT = 8
) (
    input  logic [WIDTH-1:0] res,
    input  logic             shl_byte,
    input  logic             shr_arith,
    output logic [WIDTH-1:0] shifted
);
    shift_e mode;

    always_comb begin
        mode = shift_e'({shl_byte, shr_arith});
        unique case (mode)
            SH_LEFT:  shifted = res << SHL_AMT;
            SH_RIGHT: shifted = {res[WIDTH-1], res[WIDTH-1:1]};
            SH_NONE,
            SH_BOTH:  shifted = res;
            default:  shifted = res;
        endcase
    end
endmodule

// File: rtl/mdp_alu.sv
module mdp_alu #(
    parameter int WIDTH   = 32,
    parameter int SHL_AMT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_hold,
    input  logic [WIDTH-1:0] b_bus,
    input  logic [1:0]       fn_sel,
    input  logic             en_left,
    input  logic             en_right,
    input  logic             inv_left,
    input  logic             carry_in,
    input  logic             shl_byte,
    input  logic             shr_arith,
    output logic [WIDTH-1:0] c_out,
    output logic             flag_n,
    output logic             flag_z
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] a_eff;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] alu_raw;

    mdp_operand_gate #(.WIDTH(WIDTH)) u_gate (
        .a_in     (a_hold),
        .b_in     (b_bus),
        .en_left  (en_left),
        .en_right (en_right),
        .inv_left (inv_left),
        .a_eff    (a_eff),
        .b_eff    (b_eff)
    );

    mdp_func_unit #(.WIDTH(WIDTH)) u_func (
        .a_eff    (a_eff),
        .b_eff    (b_eff),
        .fn_sel   (fn_sel),
        .carry_in (carry_in),
        .res      (alu_raw)
    );

    mdp_shifter #(.WIDTH(WIDTH), .SHL_AMT(SHL_AMT)) u_shift (
        .res       (alu_raw),
        .shl_byte  (shl_byte),
        .shr_arith (shr_arith),
        .shifted   (c_out)
    );

    // Status flags follow the unshifted result, loaded with the datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else begin
            flag_n <= alu_raw[MSB];
            flag_z <= (alu_raw == '0);
        end
    end
endmodule

// File: rtl/mdp_alu_chk.sv
module mdp_alu_chk #(
    parameter int WIDTH   = 32,
    parameter int SHL_AMT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_hold,
    input logic [WIDTH-1:0] b_bus,
    input logic [1:0]       fn_sel,
    input logic             en_left,
    input logic             en_right,
    input logic             inv_left,
    input logic             shl_byte,
    input logic             shr_arith,
    input logic [WIDTH-1:0] alu_raw,
    input logic [WIDTH-1:0] c_out,
    input logic             flag_n,
    input logic             flag_z
);
    p_flag_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_n == $past(alu_raw[WIDTH-1])));

    p_flag_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (flag_z == ($past(alu_raw) == '0)));

    p_shift_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shl_byte && !shr_arith) |->
            (c_out[SHL_AMT-1:0] == '0 &&
             c_out[WIDTH-1:SHL_AMT] == alu_raw[WIDTH-1-SHL_AMT:0]));

    p_shift_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shr_arith && !shl_byte) |->
            (c_out[WIDTH-1] == alu_raw[WIDTH-1] &&
             c_out[WIDTH-2:0] == alu_raw[WIDTH-1:1]));

    p_no_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shl_byte == shr_arith) |-> (c_out == alu_raw));

    p_logic_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_sel == 2'b00 && en_left && en_right && !inv_left) |->
            (alu_raw == (a_hold & b_bus)));

    p_logic_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_sel == 2'b01 && en_left && en_right && !inv_left) |->
            (alu_raw == (a_hold | b_bus)));
endmodule

bind mdp_alu mdp_alu_chk #(.WIDTH(WIDTH), .SHL_AMT(SHL_AMT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_hold    (a_hold),
    .b_bus     (b_bus),
    .fn_sel    (fn_sel),
    .en_left   (en_left),
    .en_right  (en_right),
    .inv_left  (inv_left),
    .shl_byte  (shl_byte),
    .shr_arith (shr_arith),
    .alu_raw   (alu_raw),
    .c_out     (c_out),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
);

// File: tb/mdp_alu_test.sv
module mdp_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    typedef struct {
        logic [31:0] c;
        logic        n;
        logic        z;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_hold = '0;
    logic [31:0] b_bus = '0;
    logic [1:0]  fn_sel = 2'b00;
    logic        en_left = 1'b0;
    logic        en_right = 1'b0;
    logic        inv_left = 1'b0;
    logic        carry_in = 1'b0;
    logic        shl_byte = 1'b0;
    logic        shr_arith = 1'b0;
    logic [31:0] c_out;
    logic        flag_n;
    logic        flag_z;

    int   applied = 0;
    int   miscompares = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    mdp_alu uut (
        .clk(clk), .rst_n(rst_n), .a_hold(a_hold), .b_bus(b_bus),
        .fn_sel(fn_sel), .en_left(en_left), .en_right(en_right),
        .inv_left(inv_left), .carry_in(carry_in), .shl_byte(shl_byte),
        .shr_arith(shr_arith), .c_out(c_out), .flag_n(flag_n), .flag_z(flag_z)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model taken from the requirement wording.
    function automatic logic [31:0] unshifted(input logic [1:0] f, input logic ea,
        input logic eb, input logic ia, input logic ci,
        input logic [31:0] a, input logic [31:0] b);
        logic [31:0] left, right;
        left  = ea ? a : 32'h0;                      // R1
        if (ia) left = ~left;                        // R2
        right = eb ? b : 32'h0;                      // R1
        if (f == 2'b00) return left & right;         // R3
        if (f == 2'b01) return left | right;         // R3
        if (f == 2'b10) return ~right;               // R4
        return left + right + {31'h0, ci};           // R5
    endfunction

    function automatic logic [31:0] after_shift(input logic [31:0] r,
        input logic sl, input logic sr);
        if (sl && !sr) return {r[23:0], 8'h00};      // R6
        if (sr && !sl) return {r[31], r[31:1]};      // R7
        return r;                                    // R8
    endfunction

    // Driver: applies one vector at the falling edge and queues its expectation.
    task automatic drive(input logic [1:0] f, input logic ea, input logic eb,
        input logic ia, input logic ci, input logic sl, input logic sr,
        input logic [31:0] a, input logic [31:0] b,
        input logic [31:0] exp_c, input logic exp_n, input logic exp_z,
        input string tag);
        exp_t e;
        @(negedge clk);
        fn_sel = f; en_left = ea; en_right = eb; inv_left = ia; carry_in = ci;
        shl_byte = sl; shr_arith = sr; a_hold = a; b_bus = b;
        e.c = exp_c; e.n = exp_n; e.z = exp_z; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic drive_model(input logic [1:0] f, input logic ea, input logic eb,
        input logic ia, input logic ci, input logic sl, input logic sr,
        input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [31:0] r;
        r = unshifted(f, ea, eb, ia, ci, a, b);
        drive(f, ea, eb, ia, ci, sl, sr, a, b, after_shift(r, sl, sr),
              r[31], (r == 32'h0), tag);
    endtask

    // Monitor: after each rising edge, the flags reflect the vector of the cycle
    // before, and c_out still holds that vector's result.
    always @(posedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            #1;
            e = sb_q.pop_front();
            applied++;
            if (c_out !== e.c || flag_n !== e.n || flag_z !== e.z) begin
                miscompares++;
                $display("FAIL %s: c_out=%h n=%b z=%b expected c_out=%h n=%b z=%b",
                         e.tag, c_out, flag_n, flag_z, e.c, e.n, e.z);
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
    end

    initial begin
        // R11: the operands give a zero result, yet the flags stay cleared in reset.
        repeat (3) @(posedge clk);
        #1;
        applied++;
        if (flag_n !== 1'b0 || flag_z !== 1'b0) begin
            miscompares++;
            $display("FAIL R11: n=%b z=%b expected n=0 z=0", flag_n, flag_z);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Identities through the one adder, with literal expectations (R5, R2, R1).
        drive(2'b11, 1, 1, 0, 0, 0, 0, 32'd7, 32'd5, 32'd12, 0, 0, "R5 A+B");
        drive(2'b11, 1, 1, 1, 1, 0, 0, 32'd7, 32'd5, 32'hFFFF_FFFE, 1, 0, "R5 B-A");
        drive(2'b11, 1, 1, 1, 1, 0, 0, 32'd5, 32'd7, 32'd2, 0, 0, "R5 B-A pos");
        drive(2'b11, 1, 0, 0, 1, 0, 0, 32'd41, 32'd9, 32'd42, 0, 0, "R5 R1 A+1");
        drive(2'b11, 1, 0, 1, 1, 0, 0, 32'd5, 32'd9, 32'hFFFF_FFFB, 1, 0, "R5 R2 -A");
        drive(2'b11, 0, 0, 0, 0, 0, 0, 32'hDEAD, 32'hBEEF, 32'd0, 0, 1, "R1 R10 const0");
        drive(2'b11, 0, 0, 0, 1, 0, 0, 32'hDEAD, 32'hBEEF, 32'd1, 0, 0, "R1 const1");
        drive(2'b11, 0, 0, 1, 0, 0, 0, 32'hDEAD, 32'hBEEF, 32'hFFFF_FFFF, 1, 0, "R2 const-1");
        drive(2'b11, 1, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'h0, 32'd0, 0, 1, "R5 R10 wrap");
        // Logic functions and enables (R3, R4, R1).
        drive(2'b00, 1, 1, 0, 0, 0, 0, 32'hF0F0_1234, 32'hFF00_FF0F, 32'hF000_1204, 1, 0, "R3 AND");
        drive(2'b01, 1, 1, 0, 0, 0, 0, 32'h0F00_0001, 32'h00F0_0010, 32'h0FF0_0011, 0, 0, "R3 OR");
        drive(2'b01, 0, 1, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0100, 32'h0000_0100, 0, 0, "R1 OR no A");
        drive(2'b10, 1, 1, 1, 0, 0, 0, 32'h1234_5678, 32'h0000_FFFF, 32'hFFFF_0000, 1, 0, "R4 NOTB");
        drive(2'b10, 0, 0, 0, 0, 0, 0, 32'h1234_5678, 32'h5555_5555, 32'hFFFF_FFFF, 1, 0, "R4 R1 NOTB gated");
        // R12: carry_in changes nothing for logic functions.
        drive(2'b00, 1, 1, 0, 1, 0, 0, 32'h0000_00F0, 32'h0000_000F, 32'd0, 0, 1, "R12 AND carry");
        drive(2'b01, 1, 1, 0, 1, 0, 0, 32'h8000_0000, 32'h0, 32'h8000_0000, 1, 0, "R12 OR carry");
        drive(2'b10, 1, 1, 0, 1, 0, 0, 32'h0, 32'hFFFF_FFFF, 32'd0, 0, 1, "R12 NOTB carry");
        // Shifter; flags come from the unshifted result (R6, R7, R8, R9, R10).
        drive(2'b11, 1, 0, 0, 0, 1, 0, 32'h8123_4567, 32'h0, 32'h2345_6700, 1, 0, "R6 R9 SLL8");
        drive(2'b11, 1, 0, 0, 0, 1, 0, 32'h1200_0000, 32'h0, 32'h0000_0000, 0, 0, "R6 R10 SLL8 to zero");
        drive(2'b11, 1, 0, 0, 0, 0, 1, 32'h8000_0002, 32'h0, 32'hC000_0001, 1, 0, "R7 SRA neg");
        drive(2'b11, 1, 0, 0, 0, 0, 1, 32'h4000_0003, 32'h0, 32'h2000_0001, 0, 0, "R7 SRA pos");
        drive(2'b11, 1, 0, 0, 0, 0, 1, 32'h0000_0001, 32'h0, 32'h0000_0000, 0, 0, "R7 R10 SRA to zero");
        drive(2'b11, 1, 0, 0, 0, 1, 1, 32'h8765_4321, 32'h0, 32'h8765_4321, 1, 0, "R8 both shifts");
        // Model-driven sweep over all control combinations.
        for (int k = 0; k < 512; k++) begin
            logic [31:0] a, b;
            a = 32'h9E37_79B9 * (k + 1);
            b = 32'h7F4A_7C15 ^ (a >> 3) ^ (k << 20);
            drive_model(k[1:0], k[2], k[3], k[4], k[5], k[6], k[7], a, b, "R1-sweep R5");
        end
        repeat (3) @(posedge clk);
        #2;
        summary();
    end
endmodule